// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control sequencer a small 16-bit processor uses to take a hardware interrupt. At each instruction boundary it decides whether a pending device request may interrupt the running program. If it may, the block runs a fixed sequence of steps while the processor core stalls:

1. If the program was running in user mode, it moves the stack pointer (R6) to a supervisor stack.
2. It rewrites the processor status word.
3. It pushes the old status word and the return PC onto the stack.
4. It reads the handler address from a vector table and loads that address into the PC.

The core owns the register file, the shadow stack pointers and memory. The sequencer only drives write strobes and data for each of them, and a read strobe toward memory. Memory reads are synchronous: the read data returns one cycle after the read strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken only when `irq_req` and `irq_en` are both high and `irq_pri` is strictly greater than the running priority, which is held in `psr_in` bits 10:8. An equal or lower priority is not taken, and `busy` stays low.
- R2: A request is taken only in a cycle where `instr_done` is high. Acceptance is registered, so `busy` rises in the following cycle.
- R3: When the program was in user mode (`psr_in` bit 15 = 1), the first cycle of the sequence writes the old R6 to the saved user stack pointer (`usp_we`). In that same cycle it loads `ssp_in` into R6 (`r6_we`).
- R4: When the program was already privileged (bit 15 = 0), no user stack pointer write and no stack switch take place. The pushes start from the R6 value that was present at acceptance.
- R5: In the first cycle of the sequence, the PSR is written with these changes: bit 15 cleared, bits 10:8 set to the device priority, and bits 2:0 cleared. All other bits are kept.
- R6: There are two pushes, in consecutive cycles. Each push decrements the stack pointer by one, writes memory at the new address, and writes that address back to R6. The first push stores the unmodified PSR and the second stores the PC, both as they were at acceptance.
- R7: After the pushes, the block reads memory at 0x0100 plus the 8-bit vector. In the next cycle it writes the returned word to the PC and pulses `done` for exactly one cycle.
- R8: `busy` is high from the first sequence cycle through the `done` cycle (five cycles). Requests seen during that time are ignored. Inputs that change after acceptance do not alter the sequence.
- R9: While reset is active, `busy`, `done` and all write and read strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | End-of-instruction strobe |
| irq_req | input | 1 | Device service request |
| irq_en | input | 1 | Device interrupt enable |
| irq_pri | input | 3 | Device priority |
| irq_vec | input | 8 | Device vector number |
| psr_in | input | 16 | Current processor status word |
| r6_in | input | 16 | Current R6 |
| pc_in | input | 16 | Return PC |
| ssp_in | input | 16 | Saved supervisor stack pointer |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |
| busy | output | 1 | Sequence in progress; core stalls |
| done | output | 1 | One-cycle pulse when the PC is loaded |
| r6_we | output | 1 | R6 write strobe |
| r6_wdata | output | 16 | R6 write data |
| usp_we | output | 1 | Saved user stack pointer write strobe |
| usp_wdata | output | 16 | Saved user stack pointer data |
| psr_we | output | 1 | PSR write strobe |
| psr_wdata | output | 16 | New PSR |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 16 | New PC |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |

## Verification
Two situations put more than one function into a single cycle.

- In the first sequence cycle, the stack switch and the PSR rewrite happen together. The bench drives entries from user mode and from privileged mode, and the reference model checks every strobe and data word in that cycle.
- A new, higher-priority request can arrive with `instr_done` while an entry is already in progress. The bench holds such a request high through a whole sequence. The model expects it to be ignored until the `done` cycle has passed, and then taken in the first idle cycle.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          DW       = 16,
  parameter int          PRI_W    = 3,
  parameter int          VEC_W    = 8,
  parameter int          PRIV_BIT = 15,
  parameter int          PRI_LSB  = 8,
  parameter int          CC_W     = 3,
  parameter logic [15:0] TBL_BASE = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_done,
  input  logic             irq_req,
  input  logic             irq_en,
  input  logic [PRI_W-1:0] irq_pri,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [DW-1:0]    psr_in,
  input  logic [DW-1:0]    r6_in,
  input  logic [DW-1:0]    pc_in,
  input  logic [DW-1:0]    ssp_in,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             r6_we,
  output logic [DW-1:0]    r6_wdata,
  output logic             usp_we,
  output logic [DW-1:0]    usp_wdata,
  output logic             psr_we,
  output logic [DW-1:0]    psr_wdata,
  output logic             pc_we,
  output logic [DW-1:0]    pc_wdata,
  output logic             mem_we,
  output logic             mem_re,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata
);

  typedef enum logic [2:0] {S_IDLE, S_SWITCH, S_PUSH_PSR, S_PUSH_PC, S_FETCH, S_LOAD} st_t;

  st_t              st;
  logic [DW-1:0]    sp, psr_old, pc_old, usp_old;
  logic [VEC_W-1:0] vec;
  logic [PRI_W-1:0] pri;
  logic             from_user;

  wire          take   = (st == S_IDLE) && instr_done && irq_req && irq_en &&
                         (irq_pri > psr_in[PRI_LSB +: PRI_W]);
  wire [DW-1:0] sp_dec = sp - DW'(1);
  wire [DW-1:0] vaddr  = TBL_BASE + DW'(vec);
  wire          pushing = (st == S_PUSH_PSR) || (st == S_PUSH_PC);

  function automatic logic [DW-1:0] entry_psr(input logic [DW-1:0] p, input logic [PRI_W-1:0] lvl);
    logic [DW-1:0] r;
    r = p;
    r[PRIV_BIT] = 1'b0;
    r[PRI_LSB +: PRI_W] = lvl;
    r[CC_W-1:0] = '0;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sp        <= '0;
      psr_old   <= '0;
      pc_old    <= '0;
      usp_old   <= '0;
      vec       <= '0;
      pri       <= '0;
      from_user <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st        <= S_SWITCH;
          psr_old   <= psr_in;
          pc_old    <= pc_in;
          usp_old   <= r6_in;
          vec       <= irq_vec;
          pri       <= irq_pri;
          from_user <= psr_in[PRIV_BIT];
          sp        <= psr_in[PRIV_BIT] ? ssp_in : r6_in;
        end
        S_SWITCH:   st <= S_PUSH_PSR;
        S_PUSH_PSR: begin st <= S_PUSH_PC; sp <= sp_dec; end
        S_PUSH_PC:  begin st <= S_FETCH;   sp <= sp_dec; end
        S_FETCH:    st <= S_LOAD;
        default:    st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_LOAD);
  assign usp_we    = (st == S_SWITCH) && from_user;
  assign usp_wdata = usp_old;
  assign psr_we    = (st == S_SWITCH);
  assign psr_wdata = entry_psr(psr_old, pri);
  assign r6_we     = usp_we || pushing;
  assign r6_wdata  = pushing ? sp_dec : sp;
  assign mem_we    = pushing;
  assign mem_re    = (st == S_FETCH);
  assign mem_addr  = pushing ? sp_dec : (mem_re ? vaddr : '0);
  assign mem_wdata = (st == S_PUSH_PSR) ? psr_old : pc_old;
  assign pc_we     = done;
  assign pc_wdata  = mem_rdata;

  AST_TAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(instr_done && irq_req && irq_en && (irq_pri > psr_in[PRI_LSB +: PRI_W]))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R7
  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R6
  AST_USP_WITH_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    usp_we |-> (r6_we && psr_we)); // R3
  AST_PUSH_FOLLOWS_PSR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> $past(psr_we)); // R6
  AST_PRIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    psr_we |-> !psr_wdata[PRIV_BIT]); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !busy); // R9

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_done = 0, irq_req = 0, irq_en = 0;
  logic [2:0] irq_pri = 0;
  logic [7:0] irq_vec = 0;
  logic [15:0] psr_in = 0, r6_in = 0, pc_in = 0, ssp_in = 0, mem_rdata = 0;
  logic busy, done, r6_we, usp_we, psr_we, pc_we, mem_we, mem_re;
  logic [15:0] r6_wdata, usp_wdata, psr_wdata, pc_wdata, mem_addr, mem_wdata;

  always #4 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_req(irq_req), .irq_en(irq_en),
    .irq_pri(irq_pri), .irq_vec(irq_vec), .psr_in(psr_in), .r6_in(r6_in), .pc_in(pc_in),
    .ssp_in(ssp_in), .mem_rdata(mem_rdata), .busy(busy), .done(done), .r6_we(r6_we),
    .r6_wdata(r6_wdata), .usp_we(usp_we), .usp_wdata(usp_wdata), .psr_we(psr_we),
    .psr_wdata(psr_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) if (mem_re) mem_rdata <= mem_addr ^ 16'h5A3C;

  typedef struct packed {
    logic busy, done, r6_we, usp_we, psr_we, pc_we, mem_we, mem_re;
    logic [15:0] r6_d, usp_d, psr_d, pc_d, addr, wd;
  } ev_t;

  ev_t q[$];
  int checks = 0, errors = 0;

  function automatic ev_t norm(input ev_t e);
    ev_t n = e;
    if (!n.r6_we)  n.r6_d  = '0;
    if (!n.usp_we) n.usp_d = '0;
    if (!n.psr_we) n.psr_d = '0;
    if (!n.pc_we)  n.pc_d  = '0;
    if (!(n.mem_we || n.mem_re)) n.addr = '0;
    if (!n.mem_we) n.wd = '0;
    return n;
  endfunction

  task automatic check(input ev_t exp, input string tag);
    ev_t act;
    act = '{busy, done, r6_we, usp_we, psr_we, pc_we, mem_we, mem_re,
            r6_wdata, usp_wdata, psr_wdata, pc_wdata, mem_addr, mem_wdata};
    checks++;
    if (norm(act) !== norm(exp)) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, norm(act), norm(exp));
    end
  endtask

  task automatic step(input logic req, en, input logic [2:0] pri, input logic [7:0] vec,
                      input logic idone, input logic [15:0] psr, r6, pc, ssp);
    bit was_idle;
    string tag;
    ev_t e;
    @(negedge clk);
    was_idle = (q.size() == 0);
    if (!rst_n) tag = "R9 reset";
    else if (was_idle) tag = "R1 R2 R8 idle";
    else case (q.size())
      5: tag = "R3 R4 R5 switch";
      4: tag = "R6 push psr";
      3: tag = "R6 push pc";
      2: tag = "R7 vector read";
      default: tag = "R7 R8 pc load";
    endcase
    if (was_idle) check('0, tag);
    else check(q.pop_front(), tag);
    irq_req = req; irq_en = en; irq_pri = pri; irq_vec = vec; instr_done = idone;
    psr_in = psr; r6_in = r6; pc_in = pc; ssp_in = ssp;
    if (was_idle && rst_n && idone && req && en && (pri > psr[10:8])) begin
      logic [15:0] sp0, va;
      sp0 = psr[15] ? ssp : r6;
      va  = 16'h0100 + {8'h00, vec};
      e = '0; e.busy = 1; e.psr_we = 1;
      e.psr_d = (psr & ~16'h8707) | ({13'd0, pri} << 8);
      if (psr[15]) begin e.usp_we = 1; e.usp_d = r6; e.r6_we = 1; e.r6_d = ssp; end
      q.push_back(e);
      e = '0; e.busy = 1; e.mem_we = 1; e.addr = sp0 - 1; e.wd = psr; e.r6_we = 1; e.r6_d = sp0 - 1;
      q.push_back(e);
      e = '0; e.busy = 1; e.mem_we = 1; e.addr = sp0 - 2; e.wd = pc; e.r6_we = 1; e.r6_d = sp0 - 2;
      q.push_back(e);
      e = '0; e.busy = 1; e.mem_re = 1; e.addr = va;
      q.push_back(e);
      e = '0; e.busy = 1; e.done = 1; e.pc_we = 1; e.pc_d = va ^ 16'h5A3C;
      q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 16'h8227, 16'h3F00, 16'h3050, 16'h3000);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 R3 R5: user-mode entry, priority 5 over 2
    step(1, 1, 5, 8'h21, 1, 16'h8227, 16'h3F00, 16'h3050, 16'h3000);
    // R8: higher request held during the sequence, inputs changed
    for (int i = 0; i < 5; i++) step(1, 1, 7, 8'h44, 1, 16'h8000, 16'h1111, 16'h2222, 16'h0ABC);
    idle(2);
    // R1: equal priority rejected
    step(1, 1, 2, 8'h10, 1, 16'h8227, 16'h3F00, 16'h3050, 16'h3000);
    idle(2);
    // R2: no instruction boundary
    step(1, 1, 7, 8'h10, 0, 16'h8227, 16'h3F00, 16'h3050, 16'h3000);
    idle(2);
    // R1: enable low
    step(1, 0, 7, 8'h10, 1, 16'h8227, 16'h3F00, 16'h3050, 16'h3000);
    idle(2);
    // R4: privileged entry, no stack switch, top vector
    step(1, 1, 6, 8'hFF, 1, 16'h0415, 16'h2E80, 16'h0610, 16'h3000);
    idle(7);
    // R1: user priority 6, device 7, vector 0
    step(1, 1, 7, 8'h00, 1, 16'hC6F2, 16'h4000, 16'hFD00, 16'h2FF0);
    idle(6);
    // R8: request held high through a sequence and taken again right after done
    for (int i = 0; i < 13; i++) step(1, 1, 3, 8'h80, 1, 16'h8100, 16'h5000, 16'h3100, 16'h2F00);
    idle(8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule